// File: doc/BRIEF.md
# Flash Protection Command Sequencer

This block sits on the write side of a parallel flash-style bus. It follows the write cycles and picks out the multi-cycle command sequences that manage sector protection.

Every sequence opens with a two-write unlock prefix. A command byte follows, and some commands take one more argument write. When a sequence completes, the block emits a single-clock command pulse. The pulse carries an operation code, together with the sector, bank, password word select and data that were captured from the bus. The protection bit storage, the array and the program/erase timers live elsewhere and act on these pulses.

The block also holds a read-mode selector. This selector tells the read path whether to return array data, secure-sector data, protection status bits or dynamic-bit status. The status modes persist, so several status reads at different sectors can follow one command without reissuing it. A reset command byte returns everything to array reads from any step.

Top module: `flash_prot_seq`

## Requirements
- R1: A sequence starts only with data AAh written at address 555h, followed by data 55h written at address 2AAh. Only address bits A10..A0 and data bits D7..D0 take part in any address or command compare; all higher bits are ignored.
- R2: A write whose low data byte is F0h, at any address and in any step, takes priority over every other interpretation of that write. It emits op 1 (reset), sets rd_mode to 0 (array) and returns the sequencer to idle.
- R3: After the unlock prefix, 88h written at 555h emits op 2 and sets rd_mode to 1 (secure sector).
- R4: After the unlock prefix, 90h written at 555h with any bank bits emits op 11. It sets rd_mode to 2 (protection status) and reports cmd_bank = A19..A18. If the very next write has low byte 00h, it emits op 3 and sets rd_mode to 0.
- R5: After the unlock prefix, 58h written at 555h emits op 12, sets rd_mode to 3 (dynamic status) and reports the bank. The status mode survives later writes that complete no command.
- R6: After the unlock prefix, 38h, C8h or 28h written at 555h waits for one argument write at any address. That write emits op 4, 5 or 6 respectively, with cmd_word = A0 and cmd_data = the full data word.
- R7: After the unlock prefix, 60h written at 555h waits for a write whose A5..A0 equal 3Ah. Data 68h there emits op 7 with cmd_sector = A19..A11. Data 60h there emits op 8.
- R8: After the unlock prefix, 48h written at 555h waits for a write at a sector address. If D0 = 1 it emits op 9; if D0 = 0 it emits op 10. Either way cmd_sector = A19..A11.
- R9: A write that does not match the expected step returns the sequencer to idle without a pulse and leaves rd_mode unchanged. That write is not re-read as a new first unlock write.
- R10: Address and data are taken on the rising edge of bus_we. A strobe held high over several clocks counts as a single write.
- R11: cmd_valid is high for exactly one clock, in the second clock after the clock that first samples bus_we high. rd_mode changes only in a cycle that carries a pulse.
- R12: A synchronous active-high rst clears any partly entered sequence, sets rd_mode to 0 and holds cmd_valid low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W (20) | Write address |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_we | input | 1 | Write strobe; a write is taken on its rising edge |
| cmd_valid | output | 1 | One-clock pulse when a sequence completes |
| cmd_op | output | 4 | Operation code of the completed sequence |
| cmd_sector | output | ADDR_W-11 (9) | Sector/group address A19..A11 captured by the final write |
| cmd_bank | output | BANK_W (2) | Bank bits A19..A18 captured by the final write |
| cmd_word | output | 1 | Password half select (A0 of the final write) |
| cmd_data | output | DATA_W (32) | Full data word of the final write |
| rd_mode | output | 2 | Read source: 0 array, 1 secure, 2 protection status, 3 dynamic status |

## Verification
One captured write can match two functions in the same cycle. It can be the argument the pending command is waiting for, and it can also be the reset command byte. The bench provokes this by writing F0h as the argument of a dynamic-bit write and as password data. It then judges the pulse: the op must be reset (1), not clear (10) or unlock (6), and rd_mode must return to array. A second overlap is a mode change that lands together with its pulse. Both must appear in the same sampled cycle, and no mode change may appear without a pulse.

// File: rtl/fpc_pkg.sv
package fpc_pkg;

    // Operation codes reported on cmd_op
    typedef enum logic [3:0] {
        OP_NONE       = 4'd0,
        OP_RESET      = 4'd1,
        OP_SEC_ENTER  = 4'd2,
        OP_SEC_EXIT   = 4'd3,
        OP_PW_PROG    = 4'd4,
        OP_PW_VERIFY  = 4'd5,
        OP_PW_UNLOCK  = 4'd6,
        OP_PPB_PROG   = 4'd7,
        OP_PPB_ERASE  = 4'd8,
        OP_DYB_SET    = 4'd9,
        OP_DYB_CLR    = 4'd10,
        OP_PROT_STAT  = 4'd11,
        OP_DYB_STAT   = 4'd12
    } op_e;

    // Read source selector
    typedef enum logic [1:0] {
        RM_ARRAY  = 2'd0,
        RM_SECURE = 2'd1,
        RM_PSTAT  = 2'd2,
        RM_DSTAT  = 2'd3
    } rmode_e;

    // Sequencer steps
    typedef enum logic [2:0] {
        S_IDLE,
        S_UNL1,
        S_UNL2,
        S_PW_ARG,
        S_PPB_ARG,
        S_DYB_ARG,
        S_EXIT_ARG
    } step_e;

    // Per-write classification flags
    typedef struct packed {
        logic       hit;
        logic       is_reset;
        logic       at_a1;
        logic       at_a2;
        logic       at_ppb;
        logic [7:0] code;
    } wr_cls_t;

    localparam logic [15:0] UNLOCK_ADDR1 = 16'h0555;
    localparam logic [15:0] UNLOCK_ADDR2 = 16'h02AA;
    localparam logic [5:0]  PPB_TAG      = 6'h3A;

    localparam logic [7:0] B_UNL1     = 8'hAA;
    localparam logic [7:0] B_UNL2     = 8'h55;
    localparam logic [7:0] B_RESET    = 8'hF0;
    localparam logic [7:0] B_SEC      = 8'h88;
    localparam logic [7:0] B_PSTAT    = 8'h90;
    localparam logic [7:0] B_EXIT     = 8'h00;
    localparam logic [7:0] B_DSTAT    = 8'h58;
    localparam logic [7:0] B_PW_PROG  = 8'h38;
    localparam logic [7:0] B_PW_VER   = 8'hC8;
    localparam logic [7:0] B_PW_UNL   = 8'h28;
    localparam logic [7:0] B_PPB      = 8'h60;
    localparam logic [7:0] B_PPB_PROG = 8'h68;
    localparam logic [7:0] B_PPB_ERA  = 8'h60;
    localparam logic [7:0] B_DYB      = 8'h48;

    // Map a password command byte to its operation
    function automatic op_e pw_op(input logic [7:0] b);
        case (b)
            B_PW_PROG: pw_op = OP_PW_PROG;
            B_PW_VER:  pw_op = OP_PW_VERIFY;
            default:   pw_op = OP_PW_UNLOCK;
        endcase
    endfunction

endpackage

// File: rtl/fpc_wr_capture.sv
module fpc_wr_capture #(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_we,
    output logic              cap_vld,
    output logic [ADDR_W-1:0] cap_addr,
    output logic [DATA_W-1:0] cap_data
);

    logic we_q;
    logic we_rise;

    assign we_rise = bus_we && !we_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            we_q    <= 1'b0;
            cap_vld <= 1'b0;
        end else begin
            we_q    <= bus_we;
            cap_vld <= we_rise;
        end
    end

    // Address and data are taken only on the strobe edge
    always_ff @(posedge clk) begin
        if (we_rise) begin
            cap_addr <= bus_addr;
            cap_data <= bus_wdata;
        end
    end

endmodule

// File: rtl/fpc_wr_classify.sv
module fpc_wr_classify #(
    parameter int CMP_AW = 11
) (
    input  logic              vld,
    input  logic [CMP_AW-1:0] lo_addr,
    input  logic [7:0]        lo_data,
    output fpc_pkg::wr_cls_t  cls
);
    import fpc_pkg::*;

    localparam logic [CMP_AW-1:0] A1 = CMP_AW'(UNLOCK_ADDR1);
    localparam logic [CMP_AW-1:0] A2 = CMP_AW'(UNLOCK_ADDR2);

    always_comb begin
        cls.hit      = vld;
        cls.is_reset = (lo_data == B_RESET);
        cls.at_a1    = (lo_addr == A1);
        cls.at_a2    = (lo_addr == A2);
        cls.at_ppb   = (lo_addr[5:0] == PPB_TAG);
        cls.code     = lo_data;
    end

endmodule

// File: rtl/fpc_seq_core.sv
module fpc_seq_core #(
    parameter int DATA_W = 32,
    parameter int SECT_W = 9,
    parameter int BANK_W = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  fpc_pkg::wr_cls_t    cls,
    input  logic [SECT_W-1:0]   arg_sect,
    input  logic [BANK_W-1:0]   arg_bank,
    input  logic                arg_word,
    input  logic [DATA_W-1:0]   arg_data,
    output logic                cmd_valid,
    output fpc_pkg::op_e        cmd_op,
    output logic [SECT_W-1:0]   cmd_sector,
    output logic [BANK_W-1:0]   cmd_bank,
    output logic                cmd_word,
    output logic [DATA_W-1:0]   cmd_data,
    output fpc_pkg::rmode_e     rd_mode
);
    import fpc_pkg::*;

    step_e  step_q, step_n;
    op_e    pend_q, pend_n;
    op_e    op_n;
    rmode_e mode_n;
    logic   fire;

    always_comb begin
        step_n = step_q;
        pend_n = pend_q;
        op_n   = OP_NONE;
        mode_n = rd_mode;
        fire   = 1'b0;
        if (cls.hit) begin
            step_n = S_IDLE;
            if (cls.is_reset) begin
                // reset byte wins over any pending argument
                fire   = 1'b1;
                op_n   = OP_RESET;
                mode_n = RM_ARRAY;
            end else begin
                unique case (step_q)
                    S_IDLE: begin
                        if (cls.at_a1 && cls.code == B_UNL1) step_n = S_UNL1;
                    end
                    S_UNL1: begin
                        if (cls.at_a2 && cls.code == B_UNL2) step_n = S_UNL2;
                    end
                    S_UNL2: begin
                        if (cls.at_a1) begin
                            case (cls.code)
                                B_SEC: begin
                                    fire   = 1'b1;
                                    op_n   = OP_SEC_ENTER;
                                    mode_n = RM_SECURE;
                                end
                                B_PSTAT: begin
                                    fire   = 1'b1;
                                    op_n   = OP_PROT_STAT;
                                    mode_n = RM_PSTAT;
                                    step_n = S_EXIT_ARG;
                                end
                                B_DSTAT: begin
                                    fire   = 1'b1;
                                    op_n   = OP_DYB_STAT;
                                    mode_n = RM_DSTAT;
                                end
                                B_PW_PROG, B_PW_VER, B_PW_UNL: begin
                                    pend_n = pw_op(cls.code);
                                    step_n = S_PW_ARG;
                                end
                                B_PPB:   step_n = S_PPB_ARG;
                                B_DYB:   step_n = S_DYB_ARG;
                                default: step_n = S_IDLE;
                            endcase
                        end
                    end
                    S_PW_ARG: begin
                        fire = 1'b1;
                        op_n = pend_q;
                    end
                    S_PPB_ARG: begin
                        if (cls.at_ppb && cls.code == B_PPB_PROG) begin
                            fire = 1'b1;
                            op_n = OP_PPB_PROG;
                        end else if (cls.at_ppb && cls.code == B_PPB_ERA) begin
                            fire = 1'b1;
                            op_n = OP_PPB_ERASE;
                        end
                    end
                    S_DYB_ARG: begin
                        fire = 1'b1;
                        op_n = cls.code[0] ? OP_DYB_SET : OP_DYB_CLR;
                    end
                    S_EXIT_ARG: begin
                        if (cls.code == B_EXIT) begin
                            fire   = 1'b1;
                            op_n   = OP_SEC_EXIT;
                            mode_n = RM_ARRAY;
                        end
                    end
                    default: step_n = S_IDLE;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            step_q    <= S_IDLE;
            pend_q    <= OP_NONE;
            rd_mode   <= RM_ARRAY;
            cmd_valid <= 1'b0;
            cmd_op    <= OP_NONE;
        end else begin
            step_q    <= step_n;
            pend_q    <= pend_n;
            rd_mode   <= mode_n;
            cmd_valid <= fire;
            if (fire) cmd_op <= op_n;
        end
    end

    // Payload registers hold the fields of the last completed sequence
    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_sector <= '0;
            cmd_bank   <= '0;
            cmd_word   <= 1'b0;
            cmd_data   <= '0;
        end else if (fire) begin
            cmd_sector <= arg_sect;
            cmd_bank   <= arg_bank;
            cmd_word   <= arg_word;
            cmd_data   <= arg_data;
        end
    end

endmodule

// File: rtl/flash_prot_seq.sv
module flash_prot_seq #(
    parameter int ADDR_W   = 20,
    parameter int DATA_W   = 32,
    parameter int CMP_AW   = 11,
    parameter int SECT_LSB = 11,
    parameter int BANK_W   = 2
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [ADDR_W-1:0]          bus_addr,
    input  logic [DATA_W-1:0]          bus_wdata,
    input  logic                       bus_we,
    output logic                       cmd_valid,
    output logic [3:0]                 cmd_op,
    output logic [ADDR_W-SECT_LSB-1:0] cmd_sector,
    output logic [BANK_W-1:0]          cmd_bank,
    output logic                       cmd_word,
    output logic [DATA_W-1:0]          cmd_data,
    output logic [1:0]                 rd_mode
);
    import fpc_pkg::*;

    localparam int SECT_W = ADDR_W - SECT_LSB;

    logic              cap_vld;
    logic [ADDR_W-1:0] cap_addr;
    logic [DATA_W-1:0] cap_data;
    wr_cls_t           cls;
    op_e               op_w;
    rmode_e            mode_w;

    fpc_wr_capture #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_cap (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_we    (bus_we),
        .cap_vld   (cap_vld),
        .cap_addr  (cap_addr),
        .cap_data  (cap_data)
    );

    fpc_wr_classify #(
        .CMP_AW (CMP_AW)
    ) u_cls (
        .vld     (cap_vld),
        .lo_addr (cap_addr[CMP_AW-1:0]),
        .lo_data (cap_data[7:0]),
        .cls     (cls)
    );

    fpc_seq_core #(
        .DATA_W (DATA_W),
        .SECT_W (SECT_W),
        .BANK_W (BANK_W)
    ) u_core (
        .clk        (clk),
        .rst        (rst),
        .cls        (cls),
        .arg_sect   (cap_addr[SECT_LSB +: SECT_W]),
        .arg_bank   (cap_addr[ADDR_W-1 -: BANK_W]),
        .arg_word   (cap_addr[0]),
        .arg_data   (cap_data),
        .cmd_valid  (cmd_valid),
        .cmd_op     (op_w),
        .cmd_sector (cmd_sector),
        .cmd_bank   (cmd_bank),
        .cmd_word   (cmd_word),
        .cmd_data   (cmd_data),
        .rd_mode    (mode_w)
    );

    assign cmd_op  = op_w;
    assign rd_mode = mode_w;

endmodule

// File: rtl/flash_prot_seq_chk.sv
module flash_prot_seq_chk (
    input logic       clk,
    input logic       rst,
    input logic       bus_we,
    input logic       cmd_valid,
    input logic [3:0] cmd_op,
    input logic [1:0] rd_mode
);

    // R11
    pulse_single_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |=> !cmd_valid);

    // R10
    pulse_after_edge_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |-> ($past(bus_we, 2) && !$past(bus_we, 3)));

    // R11
    mode_moves_with_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_mode != $past(rd_mode)) |-> cmd_valid);

    // R2
    reset_op_mode_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_op == 4'd1) |-> (rd_mode == 2'd0));

    // R3
    secure_op_mode_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_op == 4'd2) |-> (rd_mode == 2'd1));

    // R4
    pstat_op_mode_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_op == 4'd11) |-> (rd_mode == 2'd2));

    // R12
    sync_reset_chk: assert property (@(posedge clk)
        rst |=> (!cmd_valid && rd_mode == 2'd0));

    // R11
    op_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |-> (cmd_op != 4'd0));

endmodule

bind flash_prot_seq flash_prot_seq_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_we    (bus_we),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .rd_mode   (rd_mode)
);

// File: tb/tb_flash_prot_seq.sv
module tb_flash_prot_seq;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [19:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_we = 1'b0;
    logic        cmd_valid;
    logic [3:0]  cmd_op;
    logic [8:0]  cmd_sector;
    logic [1:0]  cmd_bank;
    logic        cmd_word;
    logic [31:0] cmd_data;
    logic [1:0]  rd_mode;

    int n_chk = 0;
    int n_bad = 0;

    logic        g_v, g_v2, g_word;
    logic [3:0]  g_op;
    logic [8:0]  g_sect;
    logic [1:0]  g_bank, g_mode;
    logic [31:0] g_data;

    always #2 clk = ~clk;

    flash_prot_seq dut (
        .clk        (clk),
        .rst        (rst),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_we     (bus_we),
        .cmd_valid  (cmd_valid),
        .cmd_op     (cmd_op),
        .cmd_sector (cmd_sector),
        .cmd_bank   (cmd_bank),
        .cmd_word   (cmd_word),
        .cmd_data   (cmd_data),
        .rd_mode    (rd_mode)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One write; samples the pulse two clocks later and the cycle after
    task automatic wr(input logic [19:0] a, input logic [31:0] d, input bit hold = 1'b0);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_we    = 1'b1;
        @(negedge clk);
        if (!hold) bus_we = 1'b0;
        @(negedge clk);
        g_v = cmd_valid; g_op = cmd_op; g_sect = cmd_sector; g_bank = cmd_bank;
        g_word = cmd_word; g_data = cmd_data; g_mode = rd_mode;
        @(negedge clk);
        g_v2 = cmd_valid;
        bus_we = 1'b0;
        @(negedge clk);
    endtask

    task automatic unlock();
        wr(20'h00555, 32'h0000_00AA);
        wr(20'h002AA, 32'h0000_0055);
    endtask

    task automatic pulse_is(input string req, input logic [3:0] op);
        chk(g_v == 1'b1, req, g_v, 1);
        chk(g_op == op, req, g_op, op);
        chk(g_v2 == 1'b0, {req, " one-clock"}, g_v2, 0);
    endtask

    task automatic no_pulse(input string req);
        chk(g_v == 1'b0 && g_v2 == 1'b0, req, {g_v, g_v2}, 0);
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset_state();
        do_reset();
        chk(cmd_valid == 1'b0, "R12 pulse low", cmd_valid, 0);
        chk(rd_mode == 2'd0, "R12 array mode", rd_mode, 0);
    endtask

    task automatic t_unlock_high_bits();
        // R1: upper address and data bits must be ignored
        wr(20'hFF555, 32'hABCD_12AA);
        no_pulse("R1 first unlock");
        wr(20'h7A2AA, 32'h9999_0055);
        no_pulse("R1 second unlock");
        wr(20'h40555, 32'h1234_5688);
        pulse_is("R3 secure enter", 4'd2);
        chk(g_mode == 2'd1, "R3 secure mode", g_mode, 1);
    endtask

    task automatic t_reset_cmd();
        wr(20'h3_1234, 32'h0000_00F0);
        pulse_is("R2 reset cmd", 4'd1);
        chk(g_mode == 2'd0, "R2 back to array", g_mode, 0);
    endtask

    task automatic t_prot_status();
        unlock();
        wr(20'h80555, 32'h0000_0090);
        pulse_is("R4 status enter", 4'd11);
        chk(g_mode == 2'd2, "R4 status mode", g_mode, 2);
        chk(g_bank == 2'd2, "R4 bank", g_bank, 2);
        wr(20'h00000, 32'h0000_0000);
        pulse_is("R4 exit", 4'd3);
        chk(g_mode == 2'd0, "R4 exit mode", g_mode, 0);
    endtask

    task automatic t_dyb_status();
        unlock();
        wr(20'hC0555, 32'h0000_0058);
        pulse_is("R5 dyb status", 4'd12);
        chk(g_mode == 2'd3 && g_bank == 2'd3, "R5 mode+bank", {g_mode, g_bank}, 4'hF);
        wr(20'h12345, 32'h0000_0011);
        no_pulse("R5 stray write");
        chk(rd_mode == 2'd3, "R5 mode kept", rd_mode, 3);
        wr(20'h00000, 32'h0000_00F0);
        pulse_is("R2 leave status", 4'd1);
    endtask

    task automatic t_password();
        unlock();
        wr(20'h00555, 32'h38);
        no_pulse("R6 code write");
        wr(20'h00001, 32'hDEAD_BEEF);
        pulse_is("R6 program", 4'd4);
        chk(g_word == 1'b1 && g_data == 32'hDEAD_BEEF, "R6 prog payload", {g_word, g_data}, {1'b1, 32'hDEAD_BEEF});
        unlock();
        wr(20'h00555, 32'hC8);
        wr(20'h00000, 32'h1234_5678);
        pulse_is("R6 verify", 4'd5);
        chk(g_word == 1'b0 && g_data == 32'h1234_5678, "R6 verify payload", {g_word, g_data}, {1'b0, 32'h1234_5678});
        unlock();
        wr(20'h00555, 32'h28);
        wr(20'h00001, 32'hCAFE_0011);
        pulse_is("R6 unlock", 4'd6);
        chk(rd_mode == 2'd0, "R6 mode untouched", rd_mode, 0);
    endtask

    task automatic t_ppb();
        unlock();
        wr(20'h00555, 32'h60);
        wr({9'h1A5, 11'h03A}, 32'h68);
        pulse_is("R7 ppb program", 4'd7);
        chk(g_sect == 9'h1A5, "R7 sector", g_sect, 9'h1A5);
        unlock();
        wr(20'h00555, 32'h60);
        wr({9'h033, 11'h7FA}, 32'h60);
        pulse_is("R7 ppb erase", 4'd8);
        unlock();
        wr(20'h00555, 32'h60);
        wr({9'h001, 11'h000}, 32'h68);
        no_pulse("R7 wrong tag address");
    endtask

    task automatic t_dyb();
        unlock();
        wr(20'h00555, 32'h48);
        wr({9'h007, 11'h000}, 32'h01);
        pulse_is("R8 dyb set", 4'd9);
        chk(g_sect == 9'h007, "R8 set sector", g_sect, 7);
        unlock();
        wr(20'h00555, 32'h48);
        wr({9'h100, 11'h000}, 32'h00);
        pulse_is("R8 dyb clear", 4'd10);
        chk(g_sect == 9'h100, "R8 clear sector", g_sect, 9'h100);
    endtask

    task automatic t_mismatch();
        // enter secure, then a broken sequence must not disturb it
        unlock();
        wr(20'h00555, 32'h88);
        wr(20'h00555, 32'hAA);
        wr(20'h00555, 32'h55);
        no_pulse("R9 broken unlock");
        chk(rd_mode == 2'd1, "R9 mode kept", rd_mode, 1);
        // mismatched write is not reused as a first unlock write
        wr(20'h00555, 32'hAA);
        wr(20'h00555, 32'hAA);
        wr(20'h002AA, 32'h55);
        wr(20'h00555, 32'h90);
        no_pulse("R9 no reuse");
        unlock();
        wr(20'h00555, 32'h90);
        wr(20'h00000, 32'h00);
        pulse_is("R9 recovered exit", 4'd3);
    endtask

    task automatic t_collision();
        unlock();
        wr(20'h00555, 32'h48);
        wr({9'h007, 11'h000}, 32'h0000_00F0);
        pulse_is("R2 reset beats dyb arg", 4'd1);
        unlock();
        wr(20'h00555, 32'h28);
        wr(20'h00001, 32'h1234_56F0);
        pulse_is("R2 reset beats pw arg", 4'd1);
        chk(g_mode == 2'd0, "R2 collision mode", g_mode, 0);
    endtask

    task automatic t_hold();
        wr(20'h00555, 32'hAA, 1'b1);
        wr(20'h002AA, 32'h55, 1'b1);
        wr(20'h00555, 32'h88, 1'b1);
        pulse_is("R10 held strobe", 4'd2);
        wr(20'h00000, 32'hF0);
    endtask

    task automatic t_mid_reset();
        unlock();
        do_reset();
        wr(20'h00555, 32'h88);
        no_pulse("R12 sequence cleared");
        chk(rd_mode == 2'd0, "R12 mode after", rd_mode, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog R11 actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        t_reset_state();
        t_unlock_high_bits();
        t_reset_cmd();
        t_prot_status();
        t_dyb_status();
        t_password();
        t_ppb();
        t_dyb();
        t_mismatch();
        t_collision();
        t_hold();
        t_mid_reset();
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule